// File: doc/BRIEF.md
# Duobinary circular turbo encoder

This block encodes a frame of N information couples (bit pairs A,B) into six-bit words using two 16-state recursive systematic duobinary constituent encoders. The first encoder sees the couples in natural order and the second sees them in a permuted order produced by an arithmetic interleaver. Both encoders are circular (tail-biting). Each starts in a state chosen so that it finishes the frame in that same state, so no termination bits are sent.

A frame passes through three phases. First the couples are written into an internal buffer with two read ports. Next, a pre-encoding pass runs both encoders from the all-zero state. During that pass the block also tracks the zero-input state transition raised to the power N. The circular starting states are then solved from these results. Finally, an output pass emits one word per couple on a valid/ready port. The frame length and the interleaver parameters are sampled with the first couple of each frame. A new frame is accepted only after the last word of the previous frame has been sent.

Top module: `duobinary_turbo_enc`

## Requirements
- R1: After reset, and again after the last word of a frame has been taken, `in_ready` is 1 and `out_valid` is 0.
- R2: While `in_ready` is 1, a couple is taken on each clock edge where `in_valid` is 1. The first couple taken from idle samples `cfg_len`, `cfg_p0` and `cfg_q0`..`cfg_q3` for the whole frame. Valid settings are: N between 56 and MAX_N, N not a multiple of 15, P0 below N, and each Q below N.
- R3: The output word is {A, B, Y1, W1, Y2, W2}, with A at bit 5 and W2 at bit 0. A and B are the couple in natural order j = 0..N-1.
- R4: Each constituent encoder has a state s[3:0]. For an input (a,b) it computes f = a^b^s[2]^s[3], Y = f^s[1]^s[3] and W = f^s[3]. Its next state is {s[2]^b, s[1]^a, s[0]^b, f}.
- R5: Y1,W1 come from the first encoder, which is fed couple j at step j.
- R6: Y2,W2 come from the second encoder. At step j it is fed the couple at index P(j) = (P0*j + Q[j mod 4]) mod N. A and B are swapped on odd j.
- R7: Each encoder starts its output pass in the unique state c such that encoding the frame from c ends again in c.
- R8: The first `out_valid` appears exactly N+1 clock edges after the edge that takes the last couple.
- R9: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_word` unchanged.
- R10: From the last couple taken until the last word is sent, `in_ready` is 0. An `in_valid` in that window neither alters the frame nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | LW | Frame length N in couples |
| cfg_p0 | input | LW | Interleaver multiplier P0 |
| cfg_q0 | input | LW | Interleaver offset for j mod 4 = 0 |
| cfg_q1 | input | LW | Interleaver offset for j mod 4 = 1 |
| cfg_q2 | input | LW | Interleaver offset for j mod 4 = 2 |
| cfg_q3 | input | LW | Interleaver offset for j mod 4 = 3 |
| in_valid | input | 1 | Input couple present |
| in_a | input | 1 | Couple bit A |
| in_b | input | 1 | Couple bit B |
| in_ready | output | 1 | Block can take a couple |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the word |
| out_word | output | 6 | Encoded word {A,B,Y1,W1,Y2,W2} |

## Verification
Each couple is taken on the edge where it is presented, and the first word is due N+1 edges after the last couple. The bench counts those edges from the accept edge and samples on the falling edge that follows. Words are compared in order at every falling edge where both `out_valid` and `out_ready` are high, so each word is checked in the cycle it is taken. A stalled word is re-sampled one falling edge later to confirm it is held. The expected words come from a behavioural model that finds each circular state by trying all sixteen starting states.

// File: rtl/duobinary_turbo_enc.sv
module duobinary_turbo_enc #(
  parameter int MAX_N = 2396
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(MAX_N+1)-1:0]   cfg_len,
  input  logic [$clog2(MAX_N+1)-1:0]   cfg_p0,
  input  logic [$clog2(MAX_N+1)-1:0]   cfg_q0,
  input  logic [$clog2(MAX_N+1)-1:0]   cfg_q1,
  input  logic [$clog2(MAX_N+1)-1:0]   cfg_q2,
  input  logic [$clog2(MAX_N+1)-1:0]   cfg_q3,
  input  logic                         in_valid,
  input  logic                         in_a,
  input  logic                         in_b,
  output logic                         in_ready,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [5:0]                   out_word
);
  localparam int LW = $clog2(MAX_N+1);

  typedef enum logic [2:0] {IDLE, LOAD, PRE, SOLVE, ENC} phase_t;

  function automatic logic [5:0] rsc_step(input logic [3:0] s, input logic a, input logic b);
    logic f;
    f = a ^ b ^ s[2] ^ s[3];
    return {s[2]^b, s[1]^a, s[0]^b, f, f^s[1]^s[3], f^s[3]};
  endfunction

  function automatic logic [3:0] zero_step(input logic [3:0] s);
    return {s[2], s[1], s[0], s[2]^s[3]};
  endfunction

  function automatic logic [3:0] circ_solve(input logic [3:0] fin, input logic [3:0][3:0] m);
    logic [3:0] v;
    logic [3:0] r;
    r = 4'd0;
    for (int c = 0; c < 16; c++) begin
      v = c[3:0];
      for (int i = 0; i < 4; i++)
        if (c[i]) v = v ^ m[i];
      if (v == fin) r = c[3:0];
    end
    return r;
  endfunction

  logic [1:0]          mem [MAX_N];
  phase_t              ph;
  logic [LW-1:0]       j, n_len, p0, acc;
  logic [3:0][LW-1:0]  q;
  logic [3:0]          s1, s2, c1, c2;
  logic [3:0][3:0]     bas, bas_nx;

  logic          in_fire, out_fire, last;
  logic [LW-1:0] len_eff, idx_int, acc_nx;
  logic [LW:0]   acc_sum, idx_sum;
  logic [1:0]    d_nat, d_int;
  logic          a_i, b_i;
  logic [5:0]    e1, e2;
  logic [3:0]    circ1, circ2;

  assign in_ready  = (ph == IDLE) || (ph == LOAD);
  assign out_valid = (ph == ENC);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign len_eff   = (ph == IDLE) ? cfg_len : n_len;
  assign last      = (j == n_len - LW'(1));

  assign acc_sum = {1'b0, acc} + {1'b0, p0};
  assign acc_nx  = LW'((acc_sum >= {1'b0, n_len}) ? acc_sum - {1'b0, n_len} : acc_sum);
  assign idx_sum = {1'b0, acc} + {1'b0, q[j[1:0]]};
  assign idx_int = LW'((idx_sum >= {1'b0, n_len}) ? idx_sum - {1'b0, n_len} : idx_sum);

  assign d_nat = mem[j];
  assign d_int = mem[idx_int];
  assign a_i   = j[0] ? d_int[0] : d_int[1];
  assign b_i   = j[0] ? d_int[1] : d_int[0];

  assign e1 = rsc_step(s1, d_nat[1], d_nat[0]);
  assign e2 = rsc_step(s2, a_i, b_i);
  assign out_word = {d_nat, e1[1:0], e2[1:0]};

  assign circ1 = circ_solve(s1, bas);
  assign circ2 = circ_solve(s2, bas);

  always_comb
    for (int i = 0; i < 4; i++) bas_nx[i] = zero_step(bas[i]);

  always_ff @(posedge clk)
    if (in_fire) mem[j] <= {in_a, in_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE; j <= '0; n_len <= '0; p0 <= '0; q <= '0; acc <= '0;
      s1 <= '0; s2 <= '0; c1 <= '0; c2 <= '0; bas <= '0;
    end else begin
      case (ph)
        IDLE, LOAD: if (in_fire) begin
          if (ph == IDLE) begin
            n_len <= cfg_len; p0 <= cfg_p0;
            q <= {cfg_q3, cfg_q2, cfg_q1, cfg_q0};
          end
          if (j == len_eff - LW'(1)) begin
            ph <= PRE; j <= '0; acc <= '0; s1 <= '0; s2 <= '0;
            bas <= {4'b1000, 4'b0100, 4'b0010, 4'b0001};
          end else begin
            ph <= LOAD; j <= j + LW'(1);
          end
        end
        PRE: begin
          s1 <= e1[5:2]; s2 <= e2[5:2]; bas <= bas_nx; acc <= acc_nx;
          j <= last ? '0 : j + LW'(1);
          if (last) ph <= SOLVE;
        end
        SOLVE: begin
          s1 <= circ1; s2 <= circ2; c1 <= circ1; c2 <= circ2;
          acc <= '0; j <= '0; ph <= ENC;
        end
        ENC: if (out_fire) begin
          s1 <= e1[5:2]; s2 <= e2[5:2]; acc <= acc_nx;
          j <= last ? '0 : j + LW'(1);
          if (last) ph <= IDLE;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R9

  AST_CIRC_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && last |=> (s1 == c1) && (s2 == c2)); // R7

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PRE || ph == ENC) |-> idx_int < n_len); // R6

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10

  AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == ENC) && in_valid |=> $stable(d_nat) || $past(out_fire)); // R10
endmodule

// File: tb/duobinary_turbo_enc_test.sv
module duobinary_turbo_enc_test;
  localparam int CLK_NS = 10;
  localparam int MAXN   = 2396;
  localparam int LW     = $clog2(MAXN+1);
  localparam int NV     = 5;
  localparam int VEC [NV][7] = '{
    '{56,   13,   3,    29,   11,  47,   101},
    '{64,   17,   5,    1,    33,  60,   202},
    '{100,  37,   0,    50,   25,  75,   303},
    '{212,  59,   100,  7,    199, 3,    404},
    '{2396, 1237, 17,   1200, 600, 2395, 505}
  };

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] cfg_len = '0, cfg_p0 = '0, cfg_q0 = '0, cfg_q1 = '0, cfg_q2 = '0, cfg_q3 = '0;
  logic in_valid = 0, in_a = 0, in_b = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [5:0] out_word;

  int total = 0, bad = 0, cyc = 0;
  logic [1:0] dat [MAXN];
  logic [5:0] expw [MAXN];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc++;

  duobinary_turbo_enc #(.MAX_N(MAXN)) uut (
    .clk, .rst_n, .cfg_len, .cfg_p0, .cfg_q0, .cfg_q1, .cfg_q2, .cfg_q3,
    .in_valid, .in_a, .in_b, .in_ready, .out_valid, .out_ready, .out_word);

  function automatic logic [5:0] mstep(input logic [3:0] s, input logic a, input logic b);
    logic f;
    f = a ^ b ^ s[2] ^ s[3];
    return {s[2]^b, s[1]^a, s[0]^b, f, f^s[1]^s[3], f^s[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input int n, input int p0, input int q0, input int q1,
                       input int q2, input int q3, input int seed);
    logic [15:0] lf;
    int qq [4];
    logic [3:0] c1, c2, s, sa, sb;
    logic [5:0] r;
    logic a, b;
    int p;
    qq = '{q0, q1, q2, q3};
    lf = seed[15:0] | 16'h1;
    for (int k = 0; k < n; k++) begin
      lf = {lf[14:0], lf[15]^lf[13]^lf[12]^lf[10]};
      dat[k] = lf[1:0];
    end
    c1 = 0; c2 = 0;
    for (int c = 0; c < 16; c++) begin
      sa = c[3:0]; sb = c[3:0];
      for (int k = 0; k < n; k++) begin
        r = mstep(sa, dat[k][1], dat[k][0]); sa = r[5:2];
        p = (p0*k + qq[k%4]) % n;
        a = (k%2) ? dat[p][0] : dat[p][1];
        b = (k%2) ? dat[p][1] : dat[p][0];
        r = mstep(sb, a, b); sb = r[5:2];
      end
      if (sa == c[3:0]) c1 = c[3:0];
      if (sb == c[3:0]) c2 = c[3:0];
    end
    sa = c1; sb = c2;
    for (int k = 0; k < n; k++) begin
      r = mstep(sa, dat[k][1], dat[k][0]); sa = r[5:2];
      expw[k][5:4] = dat[k];
      expw[k][3:2] = r[1:0];
      p = (p0*k + qq[k%4]) % n;
      a = (k%2) ? dat[p][0] : dat[p][1];
      b = (k%2) ? dat[p][1] : dat[p][0];
      r = mstep(sb, a, b); sb = r[5:2];
      expw[k][1:0] = r[1:0];
    end
    s = sa;
  endtask

  task automatic run_frame(input int v, input bit stall, input bit junk);
    int n, k, lat;
    bit held;
    logic [5:0] hw;
    n = VEC[v][0];
    build(n, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_len = LW'(n); cfg_p0 = LW'(VEC[v][1]);
      cfg_q0 = LW'(VEC[v][2]); cfg_q1 = LW'(VEC[v][3]);
      cfg_q2 = LW'(VEC[v][4]); cfg_q3 = LW'(VEC[v][5]);
      in_valid = 1; in_a = dat[i][1]; in_b = dat[i][0];
      if (i == 0 || i == n-1) chk(in_ready === 1'b1, "R2 in_ready during load", in_ready, 1);
      @(posedge clk);
    end
    lat = 0;
    @(negedge clk);
    in_valid = junk; in_a = 1; in_b = 0;
    while (!out_valid && lat < 5000) begin
      @(negedge clk); lat++;
      if (junk) begin in_a = ~in_a; in_b = lat[1]; end
    end
    chk(lat == n+1, "R8 first word latency", lat, n+1);
    k = 0; held = 0; hw = 0;
    while (k < n && cyc < 190000) begin
      if (k > 0 || held) @(negedge clk);
      if (held) begin
        chk(out_valid === 1'b1 && out_word === hw, "R9 stalled word held", out_word, hw);
        held = 0;
      end
      if (junk) begin
        chk(in_ready === 1'b0, "R10 in_ready low while busy", in_ready, 0);
        in_valid = 1; in_a = ~in_a; in_b = cyc[0];
      end
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (out_valid && out_ready) begin
        chk(out_word === expw[k], "R3 R4 R5 R6 R7 word", out_word, expw[k]);
        k++;
        if (k == n) in_valid = 0;
      end else if (out_valid) begin
        held = 1; hw = out_word;
      end else if (k == 0) begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    out_ready = 0; in_valid = 0;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 idle after frame", {in_ready, out_valid}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state", {in_ready, out_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 after reset release", {in_ready, out_valid}, 2);
    for (int v = 0; v < NV; v++) run_frame(v, v % 2 == 1, 1'b0);
    run_frame(0, 1'b1, 1'b1);
    run_frame(1, 1'b0, 1'b0);
    run_frame(3, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cyc < 195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 195000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule